// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Sequencer

This block is the device-side digital controller of a 16-bit delta-sigma converter that talks to a host over a three-wire serial port with an active-low chip select. After power-up it waits out an internal power-on hold. It then runs a conversion, and once the conversion completes it parks in a sleep state. When the host pulls chip select low, the block enters a data phase. In that phase it shifts the newest result out of the serial data output, most significant bit first. At the same time it reads a four-bit header from the serial data input, and that header can change the conversion rate and the power mode.

The conversion is modelled as a fixed count of system clock cycles, and the result is sampled from an input port. There are two counts: a slow one, which is the default, and a fast one. All serial pins are brought into the system clock domain before any decision is made. A data phase ends in one of two ways: after the sixteenth falling serial clock edge, or early when chip select rises. Either ending starts a fresh conversion.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset release, `busy_o` and `ref_on_o` stay low for POR_CYC cycles counted from the release, and then the first conversion starts.
- R2: A conversion keeps `busy_o` high for exactly SLOW_CYC cycles while the stored rate bit is 0, which is its reset value, and for FAST_CYC cycles while it is 1.
- R3: When a conversion ends the block sleeps: `busy_o` stays low and no new conversion starts for as long as chip select stays high.
- R4: `sdo_oe_o` is high exactly while the synchronised chip select is low.
- R5: When the data phase is entered, `sdo_o` shows bit 15 of the last completed result. Each falling serial clock edge then advances it to the next lower bit, so 16 edges return the whole result.
- R6: Serial input bits sampled on the first four rising serial clock edges of a data phase form a header, taken in arrival order as enable-high, enable-low, rate, sleep. The rate and sleep bits are stored only when the header begins with 1 then 0.
- R7: The serial input bits that follow the header in the same data phase have no effect on the stored rate or sleep bits.
- R8: The sixteenth falling serial clock edge of a data phase ends it and starts a new conversion.
- R9: A rising chip select during the data phase aborts it and starts a new conversion. A header that is incomplete when the phase is aborted is not stored.
- R10: `ref_on_o` is high during every conversion and every data phase. In sleep it is low only if the stored sleep bit is 1. A sleep bit written in a data phase therefore first turns the reference off when the conversion that follows completes.
- R11: If chip select is low while a conversion is running, `sdo_o` holds the sign bit of the previous result and serial clock edges are ignored. Shifting begins when the block reaches the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| cs_ni | input | 1 | Active-low chip select from host, asynchronous |
| sdi_i | input | 1 | Serial configuration input, asynchronous |
| result_i | input | DATA_W | Conversion result, sampled when a conversion completes |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| busy_o | output | 1 | High while a conversion is running |
| ref_on_o | output | 1 | Reference power enable |

## Verification
The bench builds the block with POR_CYC=20, SLOW_CYC=120 and FAST_CYC=48 system cycles in place of millisecond-scale defaults. With these values every conversion length can be counted exactly, and both rates, including switches between them, fit into a short run. The fast count is also long enough to hold chip select low in the middle of a conversion and toggle the serial clock there. That makes it possible to observe the held sign bit and then an uninterrupted handover into the data phase. A serial clock half period of six system cycles leaves clear margin over the two-stage synchroniser and edge detector.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_XFER  = 2'd3
  } seq_state_e;

  // header layout, first bit received lands in the MSB
  localparam int HDR_W   = 4;
  localparam int HDR_EN1 = 3;
  localparam int HDR_EN2 = 2;
  localparam int HDR_SPD = 1;
  localparam int HDR_SLP = 0;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[0] <= RST_VAL;
        else         pipe[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[s] <= RST_VAL;
        else         pipe[s] <= pipe[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= pipe[STAGES-1];

  assign q_o    = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~prev_q;
  assign fall_o = ~pipe[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic smp_i,
  input  logic bit_i,
  output logic spd_o,
  output logic slp_o
);
  localparam int CW = $clog2(HDR_W + 1);

  logic [CW-1:0]    cnt_q;
  logic [HDR_W-2:0] sr_q;
  logic [HDR_W-1:0] word;

  assign word = {sr_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
      spd_o <= 1'b0;
      slp_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (smp_i && cnt_q != CW'(HDR_W)) begin
      cnt_q <= cnt_q + 1'b1;
      sr_q  <= word[HDR_W-2:0];
      if (cnt_q == CW'(HDR_W - 1) && word[HDR_EN1] && !word[HDR_EN2]) begin
        spd_o <= word[HDR_SPD];
        slp_o <= word[HDR_SLP];
      end
    end
  end
endmodule

// File: rtl/adc_seq_shreg.sv
module adc_seq_shreg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= din_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int POR_CYC     = 25000,
  parameter int SLOW_CYC    = 240385,
  parameter int FAST_CYC    = 60024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              ref_on_o
);
  localparam int MAX_A   = (POR_CYC > SLOW_CYC) ? POR_CYC : SLOW_CYC;
  localparam int MAX_CYC = (MAX_A > FAST_CYC) ? MAX_A : FAST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC);
  localparam int TX_W    = $clog2(DATA_W);

  // bit 0 sck, bit 1 cs, bit 2 sdi
  logic [2:0] pin_q, pin_rise, pin_fall;
  logic       sck_rise, sck_fall, cs_q, cs_rise, sdi_q;

  adc_seq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, cs_ni, sck_i}),
    .q_o   (pin_q),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  assign sck_rise = pin_rise[0];
  assign sck_fall = pin_fall[0];
  assign cs_q     = pin_q[1];
  assign cs_rise  = pin_rise[1];
  assign sdi_q    = pin_q[2];

  logic unused_pins;
  assign unused_pins = ^{pin_q[0], pin_fall[2:1], pin_rise[2]};

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, period;
  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] result_q;
  logic              cap, load, spd, slp, sh_msb, in_xfer;

  assign in_xfer = (st_q == ST_XFER);
  assign period  = spd ? CNT_W'(FAST_CYC - 1) : CNT_W'(SLOW_CYC - 1);

  always_comb begin
    st_d = st_q;
    cap  = 1'b0;
    load = 1'b0;
    unique case (st_q)
      ST_POR:   if (cnt_q == CNT_W'(POR_CYC - 1)) st_d = ST_CONV;
      ST_CONV:  if (cnt_q == period) begin
                  st_d = ST_SLEEP;
                  cap  = 1'b1;
                end
      ST_SLEEP: if (!cs_q) begin
                  st_d = ST_XFER;
                  load = 1'b1;
                end
      ST_XFER:  if (cs_rise || (sck_fall && tx_q == TX_W'(DATA_W - 1))) st_d = ST_CONV;
      default:  st_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_POR;
      cnt_q    <= '0;
      tx_q     <= '0;
      result_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q)                          cnt_q <= '0;
      else if (st_q == ST_POR || st_q == ST_CONV) cnt_q <= cnt_q + 1'b1;
      if (load)                     tx_q <= '0;
      else if (in_xfer && sck_fall) tx_q <= tx_q + 1'b1;
      if (cap) result_q <= result_i;
    end
  end

  adc_seq_cfg cfg_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load),
    .smp_i (in_xfer && sck_rise),
    .bit_i (sdi_q),
    .spd_o (spd),
    .slp_o (slp)
  );

  adc_seq_shreg #(.W(DATA_W)) shreg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .din_i  (result_q),
    .shift_i(in_xfer && sck_fall),
    .msb_o  (sh_msb)
  );

  // outside the data phase the pad shows the stored sign bit
  assign sdo_o    = in_xfer ? sh_msb : result_q[DATA_W-1];
  assign sdo_oe_o = !cs_q;
  assign busy_o   = (st_q == ST_CONV);
  assign ref_on_o = (st_q == ST_CONV) || in_xfer || (st_q == ST_SLEEP && !slp);
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int SLOW_CYC = 240385,
  parameter int FAST_CYC = 60024
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       ref_on_i,
  input logic       spd_i,
  input logic       slp_i,
  input seq_state_e state_i
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     run_q <= 0;
    else if (busy_i) run_q <= run_q + 1;
    else             run_q <= 0;

  // R2
  conv_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (run_q == unsigned'(FAST_CYC) || run_q == unsigned'(SLOW_CYC)));

  // R10
  ref_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_on_i) |-> $fell(busy_i));

  // R10
  busy_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ref_on_i);

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spd_i != $past(spd_i) || slp_i != $past(slp_i)) |-> $past(state_i) == ST_XFER);
endmodule

bind adc_serial_seq adc_serial_seq_chk #(
  .SLOW_CYC(SLOW_CYC),
  .FAST_CYC(FAST_CYC)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy_o),
  .ref_on_i(ref_on_o),
  .spd_i   (spd),
  .slp_i   (slp),
  .state_i (st_q)
);

// File: tb/adc_serial_seq_tb_top.sv
module adc_serial_seq_tb_top;
  localparam int POR_CYC  = 20;
  localparam int SLOW_CYC = 120;
  localparam int FAST_CYC = 48;
  localparam int HALF     = 6;
  localparam int NVEC     = 6;

  // {result[15:0], header[3:0] (EN1,EN2,SPD,SLP), tail[11:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    32'hA5C3_AFFF, 32'h0001_CA0A, 32'h8000_9000,
    32'h7FFE_3AAA, 32'hFFFF_8555, 32'h1234_BA5A
  };

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [15:0] result = 16'h0;
  logic sdo, sdo_oe, busy, ref_on;

  int checks = 0, fails = 0;
  int run = 0, last_len = 0, drop_cnt = 0;
  bit done = 1'b0;
  logic m_spd = 1'b0, m_slp = 1'b0;

  always #10 clk = ~clk;

  adc_serial_seq #(
    .DATA_W(16), .POR_CYC(POR_CYC), .SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC), .SYNC_STAGES(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .sdi_i(sdi),
    .result_i(result), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .busy_o(busy), .ref_on_o(ref_on)
  );

  // conversion length and reference monitor
  always @(negedge clk) begin
    if (busy) begin
      run = run + 1;
      if (!ref_on) drop_cnt = drop_cnt + 1;
    end else if (run != 0) begin
      last_len = run;
      run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [3:0] hdr, input logic [11:0] tail, input int nbits,
                      output logic [15:0] got);
    logic [15:0] din;
    din = {hdr, tail};
    got = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      got[15-b] = sdo;
      sdi = din[15-b];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_conv();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] got, res;
    logic [3:0]  hdr;
    int n, d0, err;
    result = VEC[0][31:16];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !ref_on && !sdo_oe, "R1 R4 reset outputs", {busy, ref_on, sdo_oe}, 0);
    rst_n = 1'b1;
    n = 1;
    err = 0;
    @(negedge clk);
    while (!busy && n < 1000) begin
      if (ref_on) err++;
      n++;
      @(negedge clk);
    end
    chk(n == POR_CYC, "R1 power-on hold length", n, POR_CYC);
    chk(err == 0, "R1 reference off during hold", err, 0);
    wait_conv();
    chk(last_len == SLOW_CYC, "R2 default slow rate", last_len, SLOW_CYC);

    for (int i = 0; i < NVEC; i++) begin
      res = VEC[i][31:16];
      hdr = VEC[i][15:12];
      chk(ref_on == !m_slp, "R10 reference in sleep", ref_on, !m_slp);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      chk(ref_on, "R10 wake on chip select", ref_on, 1);
      chk(sdo_oe, "R4 enable with chip select low", sdo_oe, 1);
      result = (i == NVEC - 1) ? 16'h8001 : VEC[i+1][31:16];
      d0 = drop_cnt;
      xfer(hdr, VEC[i][11:0], 16, got);
      chk(got == res, "R5 shifted result", got, res);
      chk(!sdo_oe, "R4 enable off with chip select high", sdo_oe, 0);
      if (hdr[3:2] == 2'b10) begin
        m_spd = hdr[1];
        m_slp = hdr[0];
      end
      wait_conv();
      chk(last_len == (m_spd ? FAST_CYC : SLOW_CYC), "R2 R6 R7 R8 rate after header",
          last_len, m_spd ? FAST_CYC : SLOW_CYC);
      chk(drop_cnt == d0, "R10 reference kept on through next conversion", drop_cnt - d0, 0);
    end

    // R3: sleep persists while chip select high
    err = 0;
    repeat (100) begin
      @(negedge clk);
      if (busy) err++;
    end
    chk(err == 0, "R3 sleep holds", err, 0);
    chk(ref_on == !m_slp, "R10 reference off in sleep", ref_on, !m_slp);

    // R9: abort after two header bits; header 1011 must not be stored
    xfer(4'b1011, 12'h000, 2, got);
    chk(got[15:14] == 2'b10, "R9 R5 partial shift", got[15:14], 2);
    chk(busy, "R9 abort starts conversion", busy, 1);
    wait_conv();
    chk(last_len == (m_spd ? FAST_CYC : SLOW_CYC), "R9 incomplete header ignored",
        last_len, m_spd ? FAST_CYC : SLOW_CYC);

    // R11: chip select low during a conversion
    result = 16'h4000;
    xfer(4'b0000, 12'h000, 16, got);
    chk(got == 16'h8001, "R5 result after abort", got, 16'h8001);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(sdo_oe && sdo, "R11 sign held during conversion", {sdo_oe, sdo}, 3);
    repeat (2) begin
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    chk(busy && sdo, "R11 clock edges ignored while converting", {busy, sdo}, 3);
    wait_conv();
    xfer(4'b0000, 12'h000, 16, got);
    chk(got == 16'h4000, "R11 shift after conversion", got, 16'h4000);
    wait_conv();

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule